// File: doc/BRIEF.md
# Framed Serial Receiver with Early-Sync Handling

The block deserializes fixed-length data elements arriving one bit per bit clock on a serial data line. A frame-sync pulse, sampled high on a rising bit-clock edge, marks the start of an element. The first data bit is sampled a programmable number of bit clocks later, from 0 to 2. Bits arrive most significant first. When the last bit has been captured, the element is written into a parallel output register and a one-cycle valid strobe accompanies it.

Each element claims a window of bit clocks. A frame-sync pulse that lands inside the window of the element still in progress is treated as early. A configuration bit selects how early pulses are handled. In tolerant mode they are dropped and the running element completes untouched. In strict mode the partial element is thrown away and a new element is timed from the early pulse. A sticky error flag records the event until a clear input removes it.

Top module: `rxfs_rx`

## Requirements
- R1: While reset is asserted and after it is released, `elem_valid` is 0, `elem_data` is 0 and `sync_err` is 0 until an element or an error occurs.
- R2: With a frame-sync pulse accepted on edge k and delay D, data bit i (i = 0 is the MSB of the 8-bit element) is sampled on edge k+D+i. `elem_data` holds the element and `elem_valid` is 1 in the cycle that follows edge k+D+7.
- R3: `dly_sel` values 0, 1 and 2 give delays of 0, 1 and 2 bit clocks. The value 3 acts as 2. The delay is taken when the frame-sync pulse is accepted.
- R4: A frame-sync pulse on any of the edges k+1 to k+7 after an accepted pulse on edge k is early. A pulse on edge k+8 or later is not early.
- R5: With `early_ignore` = 1, an early pulse has no effect: the running element is delivered intact and `sync_err` does not rise.
- R6: With `early_ignore` = 0, an early pulse discards the running element, which never produces `elem_valid`, and sets `sync_err` to 1.
- R7: After a discarded element, the early pulse is treated as the start of a new element, timed by R2 from the edge of that pulse.
- R8: A pulse that is not early starts a new element without setting `sync_err`, so frames spaced 8 clocks apart are all delivered in order.
- R9: `sync_err` stays 1 until `err_clr` is sampled high. A clear on the same edge as an error wins, and the flag reads 0 afterwards.
- R10: `elem_valid` is high for exactly one cycle per delivered element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsync | input | 1 | Frame-sync pulse, sampled on the rising edge |
| sdata | input | 1 | Serial data bit |
| dly_sel | input | 2 | Data delay in bit clocks (0 to 2, 3 acts as 2) |
| early_ignore | input | 1 | 1: drop early frame-sync pulses, 0: abort and restart |
| err_clr | input | 1 | Clears the sync error flag |
| elem_data | output | 8 | Last completed element |
| elem_valid | output | 1 | One-cycle strobe when `elem_data` updates |
| sync_err | output | 1 | Sticky early-sync error flag |

## Verification
The hardest case to reach from the ports is an early pulse on the exact edge where the running element captures its last bit. With zero delay, the restart and the completion then compete on the same edge, and the completed data must lose. The bench reaches this case with a task that builds a two-frame schedule from a gap count. The task places the second pulse exactly 7 clocks after the first and supplies the serial bits of each frame at the positions R2 dictates. The same schedule with gap 8 confirms the boundary in the other direction.

// File: rtl/rxfs_pkg.sv
`timescale 1ns/1ps
package rxfs_pkg;
  // Control handed from the frame timer to the shifter.
  typedef struct packed {
    logic start;  // capture first data bit on this edge
    logic abort;  // drop the element in progress
  } rxfs_ctl_t;
endpackage

// File: rtl/rxfs_rst_sync.sv
`timescale 1ns/1ps
module rxfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/rxfs_frame_ctl.sv
`timescale 1ns/1ps
module rxfs_frame_ctl
  import rxfs_pkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int MAX_DLY = 2,
  parameter int DLY_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             ignore_i,
  input  logic             clr_i,
  output rxfs_ctl_t        ctl_o,
  output logic             err_o
);
  localparam int CW = $clog2(ELEM_W + 1);

  logic [CW-1:0]    win_q, win_d;
  logic             pend_q, pend_d;
  logic [DLY_W-1:0] pcnt_q, pcnt_d;
  logic             err_q, err_d;
  logic [DLY_W-1:0] dly_eff;
  logic             in_win, early, abort, accept, start;

  // Clamp the requested delay to the supported range.
  assign dly_eff = (dly_i > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : dly_i;

  // Window covers the edges after an accepted pulse up to ELEM_W-1.
  assign in_win = (win_q != '0);
  assign early  = fs_i & in_win;
  assign abort  = early & ~ignore_i;
  assign accept = (fs_i & ~in_win) | abort;

  always_comb begin
    win_d  = win_q;
    pend_d = pend_q;
    pcnt_d = pcnt_q;
    err_d  = err_q;
    start  = 1'b0;

    if (accept)      win_d = CW'(1);
    else if (in_win) win_d = (win_q == CW'(ELEM_W - 1)) ? '0 : win_q + CW'(1);

    if (accept) begin
      start  = (dly_eff == '0);
      pend_d = (dly_eff != '0);
      pcnt_d = dly_eff - DLY_W'(1);
    end else if (pend_q) begin
      if (pcnt_q == '0) begin
        start  = 1'b1;
        pend_d = 1'b0;
      end else begin
        pcnt_d = pcnt_q - DLY_W'(1);
      end
    end

    if (clr_i)      err_d = 1'b0;
    else if (abort) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      pend_q <= 1'b0;
      pcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      win_q  <= win_d;
      pend_q <= pend_d;
      pcnt_q <= pcnt_d;
      err_q  <= err_d;
    end
  end

  assign ctl_o.start = start;
  assign ctl_o.abort = abort;
  assign err_o       = err_q;

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_i) |=> err_q);
  p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !err_q);
  p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_i && !err_q) |=> !err_q);
  p_abort_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !clr_i) |=> err_q);
endmodule

// File: rtl/rxfs_shifter.sv
`timescale 1ns/1ps
module rxfs_shifter
  import rxfs_pkg::*;
#(
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_i,
  input  rxfs_ctl_t         ctl_i,
  output logic [ELEM_W-1:0] data_o,
  output logic              valid_o
);
  localparam int BW = $clog2(ELEM_W);

  logic [ELEM_W-1:0] sh_q, sh_d;
  logic [BW-1:0]     cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic [ELEM_W-1:0] out_q, out_d;
  logic              vld_q, vld_d;
  logic [ELEM_W-1:0] sh_next;

  assign sh_next = {sh_q[ELEM_W-2:0], din_i};

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    out_d  = out_q;
    vld_d  = 1'b0;

    if (ctl_i.start) begin
      // A restart also lands here and overrides any completion.
      sh_d   = {{(ELEM_W-1){1'b0}}, din_i};
      cnt_d  = BW'(1);
      busy_d = 1'b1;
    end else if (ctl_i.abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      sh_d = sh_next;
      if (cnt_q == BW'(ELEM_W - 1)) begin
        out_d  = sh_next;
        vld_d  = 1'b1;
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      out_q  <= out_d;
      vld_q  <= vld_d;
    end
  end

  assign data_o  = out_q;
  assign valid_o = vld_q;

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.start && !ctl_i.abort) |-> !busy_q);
endmodule

// File: rtl/rxfs_rx.sv
`timescale 1ns/1ps
module rxfs_rx
  import rxfs_pkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int MAX_DLY = 2,
  parameter int DLY_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              sdata,
  input  logic [DLY_W-1:0]  dly_sel,
  input  logic              early_ignore,
  input  logic              err_clr,
  output logic [ELEM_W-1:0] elem_data,
  output logic              elem_valid,
  output logic              sync_err
);
  logic      rst_q_n;
  rxfs_ctl_t ctl;

  rxfs_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  rxfs_frame_ctl #(.ELEM_W(ELEM_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .fs_i     (fsync),
    .dly_i    (dly_sel),
    .ignore_i (early_ignore),
    .clr_i    (err_clr),
    .ctl_o    (ctl),
    .err_o    (sync_err)
  );

  rxfs_shifter #(.ELEM_W(ELEM_W)) u_shf (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .din_i   (sdata),
    .ctl_i   (ctl),
    .data_o  (elem_data),
    .valid_o (elem_valid)
  );

  p_abort_drop_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl.abort |=> !elem_valid);
endmodule

// File: tb/rxfs_rx_tb.sv
`timescale 1ns/1ps
module rxfs_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n, fsync, sdata, early_ignore, err_clr;
  logic [1:0] dly_sel;
  logic [7:0] elem_data;
  logic       elem_valid, sync_err;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  logic [7:0] vlog [0:15];
  bit done = 0;

  always #10 clk = ~clk;

  rxfs_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
    .dly_sel(dly_sel), .early_ignore(early_ignore), .err_clr(err_clr),
    .elem_data(elem_data), .elem_valid(elem_valid), .sync_err(sync_err)
  );

  always @(posedge clk) begin
    #5;
    if (elem_valid === 1'b1) begin
      vlog[vcount % 16] = elem_data;
      vcount++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic d, input logic c);
    @(negedge clk);
    fsync = f; sdata = d; err_clr = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic clear_err();
    cyc(1'b0, 1'b0, 1'b1);
    idle(2);
  endtask

  // Two frame-sync pulses gap clocks apart, data per R2 timing.
  task automatic frames(input logic [7:0] b1, input logic [7:0] b2, input int d,
                        input int gap, input bit ign, input bit clr_at2);
    int dd = (d > 2) ? 2 : d;
    dly_sel = d[1:0];
    early_ignore = ign;
    for (int c = 0; c < gap + dd + 8; c++) begin
      bit in1 = (c >= dd) && (c < dd + 8);
      bit in2 = (c >= gap + dd) && (c < gap + dd + 8);
      logic bv;
      if (in1 && (ign || !in2)) bv = b1[7 - (c - dd)];
      else if (in2)             bv = b2[7 - (c - gap - dd)];
      else                      bv = 1'b0;
      cyc((c == 0) || (c == gap), bv, clr_at2 && (c == gap));
    end
    idle(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fsync = 0; sdata = 0; err_clr = 0; early_ignore = 0; dly_sel = 0;
    repeat (3) @(negedge clk);
    chk(elem_valid === 1'b0, "R1 valid in reset", elem_valid, 0);
    chk(sync_err === 1'b0, "R1 err in reset", sync_err, 0);
    chk(elem_data === 8'h00, "R1 data in reset", elem_data, 0);
    rst_n = 1'b1;
    idle(4);
    chk(elem_valid === 1'b0 && sync_err === 1'b0, "R1 after release",
        {elem_valid, sync_err}, 0);
  endtask

  task automatic t_single(input logic [7:0] b, input int d);
    int dd = (d > 2) ? 2 : d;
    dly_sel = d[1:0];
    early_ignore = 1'b0;
    for (int c = 0; c < dd + 8; c++)
      cyc(c == 0, (c >= dd) ? b[7 - (c - dd)] : 1'b0, 1'b0);
    @(negedge clk);
    chk(elem_valid === 1'b1, $sformatf("R2 R3 valid timing d=%0d", d), elem_valid, 1);
    chk(elem_data === b, $sformatf("R2 R3 data d=%0d", d), elem_data, b);
    fsync = 0;
    @(negedge clk);
    chk(elem_valid === 1'b0, "R10 single-cycle strobe", elem_valid, 0);
    idle(2);
  endtask

  task automatic t_back2back(input int d, input int gap);
    int v0 = vcount;
    frames(8'h12, 8'h34, d, gap, 1'b0, 1'b0);
    chk(vcount - v0 == 2, $sformatf("R8 R4 count gap=%0d d=%0d", gap, d), vcount - v0, 2);
    chk(vlog[v0 % 16] === 8'h12, "R8 first element", vlog[v0 % 16], 8'h12);
    chk(vlog[(v0 + 1) % 16] === 8'h34, "R8 second element", vlog[(v0 + 1) % 16], 8'h34);
    chk(sync_err === 1'b0, "R8 no error", sync_err, 0);
  endtask

  task automatic t_abort(input int d, input int gap);
    int v0;
    clear_err();
    v0 = vcount;
    frames(8'h55, 8'hAA, d, gap, 1'b0, 1'b0);
    chk(vcount - v0 == 1, $sformatf("R6 R4 discard gap=%0d d=%0d", gap, d), vcount - v0, 1);
    chk(vlog[v0 % 16] === 8'hAA, "R7 restarted element", vlog[v0 % 16], 8'hAA);
    chk(sync_err === 1'b1, "R6 error set", sync_err, 1);
  endtask

  task automatic t_ignore(input int d, input int gap);
    int v0;
    clear_err();
    v0 = vcount;
    frames(8'h5A, 8'hF0, d, gap, 1'b1, 1'b0);
    chk(vcount - v0 == 1, $sformatf("R5 one element gap=%0d d=%0d", gap, d), vcount - v0, 1);
    chk(vlog[v0 % 16] === 8'h5A, "R5 element intact", vlog[v0 % 16], 8'h5A);
    chk(sync_err === 1'b0, "R5 no error", sync_err, 0);
  endtask

  task automatic t_sticky();
    idle(12);
    chk(sync_err === 1'b1, "R9 flag holds", sync_err, 1);
    cyc(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    err_clr = 1'b0;
    chk(sync_err === 1'b0, "R9 cleared", sync_err, 0);
  endtask

  task automatic t_clr_same_edge();
    int v0;
    clear_err();
    v0 = vcount;
    frames(8'h0F, 8'hC6, 1, 3, 1'b0, 1'b1);
    chk(sync_err === 1'b0, "R9 clear wins over set", sync_err, 0);
    chk(vcount - v0 == 1 && vlog[v0 % 16] === 8'hC6, "R7 restart under clear",
        vlog[v0 % 16], 8'hC6);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single(8'hA5, 0);
    t_single(8'h3C, 1);
    t_single(8'hC3, 2);
    t_single(8'h81, 3);
    t_back2back(2, 8);
    t_back2back(0, 8);
    t_back2back(1, 11);
    t_abort(0, 1);
    t_abort(0, 7);
    t_abort(2, 4);
    t_sticky();
    t_ignore(0, 7);
    t_ignore(2, 3);
    t_clr_same_edge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule